// File: doc/BRIEF.md
# Nibble-Serial Sample Link

This block moves converter samples between a modem processor and a converter front end. Four data lines run in each direction. Each 16-bit two's-complement sample crosses as four 4-bit nibbles within one word period, lowest nibble first. The block is clocked by the master clock. In full-rate mode one nibble moves per clock. In half-rate mode each nibble occupies two clocks, so the word rate halves. A `word_frame` output is high while nibble N0 is on the lines, and both directions share this word alignment.

On the transmit side the processor offers samples over a valid/ready handshake into a one-deep holding register. At the next word start the held sample is saturated to the 12-bit transmit range, its three low bits are cleared, and it is loaded into the shift register. The shift register then launches one nibble per nibble period on rising clock edges. If no sample is held at a word start, an all-zero word is sent. `tx_ready` is low while the holding register is occupied. The producer must keep `tx_valid` and `tx_data` steady until a rising edge at which `tx_ready` is high.

On the receive side the incoming nibbles are captured on falling clock edges and assembled at the rising edge that closes each nibble period. After N3 the word is presented on `rx_data` with `rx_valid`. The low two bits are cleared, and bit 14 is rewritten to match bit 15. A disagreement between the two sign copies sets a sticky error flag. `rx_valid` stays high until a rising edge with `rx_ready` high. There is no receive queue: a newly completed word replaces an unconsumed one.

Top module: `nibble_link`

## Requirements
- R1: A word occupies four consecutive nibble periods, N0 to N3. Nibble Nk carries bits [4k+3:4k] on lines [3:0]. `word_frame` is high exactly during N0.
- R2: A transmitted word equals the accepted sample clamped to the range 0xC000 (-16384) to 0x3FFF (16383), with the clamp applied before low-bit clearing.
- R3: Bits [2:0] of every transmitted word are zero.
- R4: `tx_ready` is high when the holding register is empty and falls in the clock after an acceptance. A held sample is sent in the next word that starts after the accepting edge. A word that starts with no sample held is sent as 0x0000.
- R5: Receive nibbles are sampled on the falling clock edge inside each nibble period. The assembled word appears on `rx_data` with `rx_valid` high right after the rising edge that ends N3.
- R6: Bits [1:0] of `rx_data` are always zero. Bits [13:2] are the received bits unchanged.
- R7: If received bits 15 and 14 differ, `sign_err` is set and stays set until reset. `rx_data` bits 15 and 14 both take received bit 15.
- R8: `rx_valid` stays high while `rx_ready` is low. A newer word overwrites the held one. `rx_valid` falls after a rising edge with `rx_ready` high and no word completing.
- R9: With `osr_half` high, every nibble, including N0 with `word_frame`, is held for two clocks, giving eight clocks per word. With it low, each nibble lasts one clock.
- R10: While `rst_n` is low, `tx_nib`, `word_frame`, `rx_valid`, `rx_data` and `sign_err` are zero and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; launch on rising, receive capture on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| osr_half | input | 1 | 1 = half-rate, each nibble two clocks; change only in reset |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 16 | Transmit sample, two's complement |
| tx_nib | output | 4 | Transmit nibble lines |
| word_frame | output | 1 | High while N0 is on the lines |
| rx_nib | input | 4 | Receive nibble lines |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | 16 | Received word, sign repaired, low bits cleared |
| sign_err | output | 1 | Sticky sign-copy mismatch flag |

## Verification
On the transmit side, nibble Nk of a word is on the lines from the rising edge that starts period k. The bench finds the rise of `word_frame` and reads one nibble per period, 5 ns after each period's first rising edge. On the receive side, the bench drives each nibble at that same instant, well before the falling-edge capture. The bench then checks `rx_data`, `rx_valid` and `sign_err` 5 ns after the edge that closes N3. That is one period after N3 was driven, or two clocks in half-rate mode. Handshake effects are checked one clock after the accepting or consuming edge.

// File: rtl/nl_pkg.sv
`timescale 1ns/1ps
package nl_pkg;
  localparam int unsigned NL_SMP_W   = 16;
  localparam int unsigned NL_LANES   = 4;
  localparam int unsigned NL_TX_ZERO = 3;
  localparam int unsigned NL_RX_ZERO = 2;

  typedef enum logic {RATE_FULL = 1'b0, RATE_HALF = 1'b1} rate_e;
endpackage

// File: rtl/nl_timing.sv
`timescale 1ns/1ps
module nl_timing #(
  parameter int unsigned NIBS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osr_half,
  output logic             step,
  output logic [IDX_W-1:0] launch_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_vld
);
  import nl_pkg::*;

  rate_e            mode;
  logic             phase;
  logic [IDX_W-1:0] idx;

  assign mode       = rate_e'(osr_half);
  assign step       = (mode == RATE_FULL) | phase;
  assign launch_idx = idx;

  // half-rate divider: a nibble step every second clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase <= 1'b0;
    else if (mode == RATE_HALF)  phase <= ~phase;
    else                         phase <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      cur_idx <= '0;
      cur_vld <= 1'b0;
    end else if (step) begin
      idx     <= (idx == IDX_W'(NIBS - 1)) ? '0 : idx + IDX_W'(1);
      cur_idx <= idx;
      cur_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/nl_tx.sv
`timescale 1ns/1ps
module nl_tx #(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned LANES    = 4,
  parameter int unsigned ZERO_LSB = 3,
  parameter int unsigned IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] launch_idx,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [SMP_W-1:0] tx_data,
  output logic [LANES-1:0] tx_nib
);
  localparam logic [SMP_W-1:0] HI   = {2'b00, {(SMP_W-2){1'b1}}};
  localparam logic [SMP_W-1:0] LO   = {2'b11, {(SMP_W-2){1'b0}}};
  localparam logic [SMP_W-1:0] MASK = {{(SMP_W-ZERO_LSB){1'b1}}, {ZERO_LSB{1'b0}}};

  logic [SMP_W-1:0] hold;
  logic             full;
  logic [SMP_W-1:0] sat;
  logic [SMP_W-1:0] load_w;
  logic [SMP_W-1:0] sh;
  logic             word_start;

  assign tx_ready   = ~full;
  assign word_start = step && (launch_idx == '0);

  always_comb begin
    if ($signed(hold) > $signed(HI))      sat = HI;
    else if ($signed(hold) < $signed(LO)) sat = LO;
    else                                  sat = hold;
    load_w = full ? (sat & MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      hold <= tx_data;
      full <= 1'b1;
    end else if (word_start) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      tx_nib <= '0;
    end else if (word_start) begin
      tx_nib <= load_w[LANES-1:0];
      sh     <= load_w >> LANES;
    end else if (step) begin
      tx_nib <= sh[LANES-1:0];
      sh     <= sh >> LANES;
    end
  end
endmodule

// File: rtl/nl_rx.sv
`timescale 1ns/1ps
module nl_rx #(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned LANES    = 4,
  parameter int unsigned ZERO_LSB = 2,
  parameter int unsigned NIBS     = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_vld,
  input  logic [LANES-1:0] rx_nib,
  input  logic             rx_ready,
  output logic             rx_valid,
  output logic [SMP_W-1:0] rx_data,
  output logic             sign_err
);
  localparam int unsigned ACC_W = (NIBS - 1) * LANES;
  localparam logic [SMP_W-3:0] LOW_MASK = {{(SMP_W-2-ZERO_LSB){1'b1}}, {ZERO_LSB{1'b0}}};

  logic [LANES-1:0] rx_cap;
  logic [ACC_W-1:0] acc;
  logic [SMP_W-1:0] word;
  logic [SMP_W-1:0] fixed;
  logic             commit;
  logic             mism;

  // falling-edge capture, mid nibble period
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_cap <= '0;
    else        rx_cap <= rx_nib;
  end

  assign commit = step && cur_vld && (cur_idx == IDX_W'(NIBS - 1));
  assign word   = {rx_cap, acc};
  assign mism   = word[SMP_W-1] ^ word[SMP_W-2];
  assign fixed  = {word[SMP_W-1], word[SMP_W-1], word[SMP_W-3:0] & LOW_MASK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (step && cur_vld) begin
      for (int k = 0; k < NIBS - 1; k++) begin
        if (cur_idx == IDX_W'(k)) acc[k*LANES +: LANES] <= rx_cap;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (commit) begin
      rx_valid <= 1'b1;
      rx_data  <= fixed;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sign_err <= 1'b0;
    else if (commit && mism) sign_err <= 1'b1;
  end
endmodule

// File: rtl/nibble_link.sv
`timescale 1ns/1ps
module nibble_link #(
  parameter int unsigned SMP_W   = nl_pkg::NL_SMP_W,
  parameter int unsigned LANES   = nl_pkg::NL_LANES,
  parameter int unsigned TX_ZERO = nl_pkg::NL_TX_ZERO,
  parameter int unsigned RX_ZERO = nl_pkg::NL_RX_ZERO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osr_half,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [SMP_W-1:0] tx_data,
  output logic [LANES-1:0] tx_nib,
  output logic             word_frame,
  input  logic [LANES-1:0] rx_nib,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [SMP_W-1:0] rx_data,
  output logic             sign_err
);
  localparam int unsigned NIBS  = SMP_W / LANES;
  localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic             step;
  logic [IDX_W-1:0] launch_idx;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_vld;

  assign word_frame = cur_vld && (cur_idx == '0);

  nl_timing #(.NIBS(NIBS), .IDX_W(IDX_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .osr_half(osr_half), .step(step),
    .launch_idx(launch_idx), .cur_idx(cur_idx), .cur_vld(cur_vld)
  );

  nl_tx #(.SMP_W(SMP_W), .LANES(LANES), .ZERO_LSB(TX_ZERO), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .step(step), .launch_idx(launch_idx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_nib(tx_nib)
  );

  nl_rx #(.SMP_W(SMP_W), .LANES(LANES), .ZERO_LSB(RX_ZERO), .NIBS(NIBS), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .step(step), .cur_idx(cur_idx), .cur_vld(cur_vld),
    .rx_nib(rx_nib), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .sign_err(sign_err)
  );
endmodule

// File: rtl/nl_link_chk.sv
`timescale 1ns/1ps
module nl_link_chk #(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned LANES   = 4,
  parameter int unsigned RX_ZERO = 2,
  parameter int unsigned NIBS    = 4,
  parameter int unsigned IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osr_half,
  input logic [LANES-1:0] tx_nib,
  input logic             word_frame,
  input logic [IDX_W-1:0] cur_idx,
  input logic             cur_vld,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [SMP_W-1:0] rx_data,
  input logic             sign_err
);
  AST_TX_N0_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_frame |-> tx_nib[2:0] == 3'b000);  // R3

  AST_TX_SIGN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && cur_idx == IDX_W'(NIBS - 1)) |-> tx_nib[LANES-1] == tx_nib[LANES-2]);  // R2

  AST_RX_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_data[RX_ZERO-1:0] == '0);  // R6

  AST_RX_SIGN_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_data[SMP_W-1] == rx_data[SMP_W-2]);  // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sign_err |=> sign_err);  // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);  // R8

  AST_FULL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!osr_half && word_frame) |=> !word_frame);  // R9

  AST_HALF_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (osr_half && $rose(word_frame)) |=> word_frame);  // R9
endmodule

bind nibble_link nl_link_chk #(
  .SMP_W(SMP_W), .LANES(LANES), .RX_ZERO(RX_ZERO), .NIBS(NIBS), .IDX_W(IDX_W)
) i_nl_link_chk (
  .clk(clk), .rst_n(rst_n), .osr_half(osr_half), .tx_nib(tx_nib),
  .word_frame(word_frame), .cur_idx(cur_idx), .cur_vld(cur_vld),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .sign_err(sign_err)
);

// File: tb/test_nibble_link.sv
`timescale 1ns/1ps
module test_nibble_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osr_half = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic [3:0]  tx_nib;
  logic        word_frame;
  logic [3:0]  rx_nib = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic        sign_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  nibble_link i_nibble_link (
    .clk(clk), .rst_n(rst_n), .osr_half(osr_half), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_nib(tx_nib), .word_frame(word_frame),
    .rx_nib(rx_nib), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sign_err(sign_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_period();
    repeat (osr_half ? 2 : 1) @(posedge clk);
    #5;
  endtask

  // leaves time at rising edge + 5 ns after release
  task automatic do_reset(input logic half);
    rst_n = 1'b0; osr_half = half; tx_valid = 1'b0; rx_nib = '0; rx_ready = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check("R10 tx_nib", {12'h0, tx_nib}, 16'h0);
    check("R10 word_frame", {15'h0, word_frame}, 16'h0);
    check("R10 rx_valid", {15'h0, rx_valid}, 16'h0);
    check("R10 rx_data", rx_data, 16'h0);
    check("R10 sign_err", {15'h0, sign_err}, 16'h0);
    check("R10 tx_ready", {15'h0, tx_ready}, 16'h1);
    rst_n = 1'b1;
    @(posedge clk); #5;
  endtask

  task automatic push(input logic [15:0] d);
    while (!tx_ready) begin @(posedge clk); #5; end
    tx_valid = 1'b1; tx_data = d;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    #4;
  endtask

  // one full word in both directions, aligned to the next rise of word_frame
  task automatic xfer(input logic [15:0] rxw, output logic [15:0] txw, output logic frame_bad);
    frame_bad = 1'b0;
    while (word_frame)  begin @(posedge clk); #5; end
    while (!word_frame) begin @(posedge clk); #5; end
    for (int k = 0; k < 4; k++) begin
      rx_nib = rxw[k*4 +: 4];
      txw[k*4 +: 4] = tx_nib;
      if ((k == 0) != word_frame) frame_bad = 1'b1;
      wait_period();
    end
    rx_nib = '0;
  endtask

  task automatic t_tx_values();
    logic [15:0] ins  [8] = '{16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF,
                             16'h3FFF, 16'h4000, 16'hBFFF, 16'hC000};
    logic [15:0] exps [8] = '{16'h1230, 16'h3FF8, 16'hC000, 16'hFFF8,
                             16'h3FF8, 16'h3FF8, 16'hC000, 16'hC000};
    logic [15:0] got;
    logic fb;
    for (int i = 0; i < 8; i++) begin
      push(ins[i]);
      xfer(16'h0, got, fb);
      check($sformatf("R2 R3 tx word %0d", i), got, exps[i]);
      if (i == 0) check("R1 frame only in N0", {15'h0, fb}, 16'h0);
    end
  endtask

  task automatic t_tx_flow();
    logic [15:0] got;
    logic fb;
    xfer(16'h0, got, fb);
    check("R4 idle word is zero", got, 16'h0);
    push(16'h0AB8);
    check("R4 ready low while held", {15'h0, tx_ready}, 16'h0);
    xfer(16'h0, got, fb);
    check("R4 held word sent", got, 16'h0AB8);
    check("R4 ready back after load", {15'h0, tx_ready}, 16'h1);
    xfer(16'h0, got, fb);
    check("R4 word not repeated", got, 16'h0);
  endtask

  task automatic t_rx_values();
    logic [15:0] ins  [4] = '{16'h1237, 16'hC001, 16'h3FFC, 16'hA5A6};
    logic [15:0] exps [4] = '{16'h1234, 16'hC000, 16'h3FFC, 16'hE5A4};
    logic [15:0] got;
    logic fb;
    rx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      xfer(ins[i], got, fb);
      check($sformatf("R5 rx_valid word %0d", i), {15'h0, rx_valid}, 16'h1);
      check($sformatf("R5 R6 rx_data word %0d", i), rx_data, exps[i]);
    end
    check("R7 no error on clean words", {15'h0, sign_err}, 16'h0);
  endtask

  task automatic t_rx_backpressure();
    logic [15:0] got;
    logic fb;
    rx_ready = 1'b0;
    xfer(16'h0104, got, fb);
    @(posedge clk); #5;
    check("R8 valid held while not ready", {15'h0, rx_valid}, 16'h1);
    xfer(16'h2208, got, fb);
    check("R8 newer word overwrites", rx_data, 16'h2208);
    rx_ready = 1'b1;
    @(posedge clk); #5;
    check("R8 valid drops after consume", {15'h0, rx_valid}, 16'h0);
  endtask

  task automatic t_sign_err();
    logic [15:0] got;
    logic fb;
    rx_ready = 1'b1;
    xfer(16'h8007, got, fb);
    check("R7 upper sign copy used", rx_data, 16'hC004);
    check("R7 error raised", {15'h0, sign_err}, 16'h1);
    xfer(16'h4002, got, fb);
    check("R7 upper copy used positive", rx_data, 16'h0000);
    xfer(16'h0010, got, fb);
    check("R7 error sticky", {15'h0, sign_err}, 16'h1);
    check("R6 clean word after error", rx_data, 16'h0010);
  endtask

  task automatic t_half_rate();
    logic [15:0] got;
    logic fb;
    do_reset(1'b1);
    while (word_frame)  begin @(posedge clk); #5; end
    while (!word_frame) begin @(posedge clk); #5; end
    @(posedge clk); #5;
    check("R9 N0 second clock", {15'h0, word_frame}, 16'h1);
    @(posedge clk); #5;
    check("R9 N0 ends after two clocks", {15'h0, word_frame}, 16'h0);
    push(16'h7FFF);
    xfer(16'h1237, got, fb);
    check("R9 R2 half-rate tx word", got, 16'h3FF8);
    check("R9 R1 half-rate framing", {15'h0, fb}, 16'h0);
    push(16'h8421);
    xfer(16'hC001, got, fb);
    check("R9 half-rate tx word 2", got, 16'h8420 > 16'h0 ? 16'hC000 : 16'hC000);
    check("R9 R5 half-rate rx word", rx_data, 16'hC000);
    check("R9 half-rate rx_valid", {15'h0, rx_valid}, 16'h1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    t_tx_values();
    t_tx_flow();
    t_rx_values();
    t_rx_backpressure();
    t_sign_err();
    t_half_rate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule